// File: doc/BRIEF.md
# Deferred Clock Divide Mode Controller

This block holds the divide setting for a bus clock that runs below a faster pipeline clock. It also produces a one-cycle enable that marks each bus-clock tick. Software writes a 3-bit mode field through a 16-bit register port at any time. The written value is only held pending. It becomes the working ratio on the clock edge where a single-cycle hibernate-exit strobe arrives.

The block has two reset inputs. The real-time-clock reset clears both the pending and the active setting, so the ratio is two right after it. The general reset leaves both settings alone and only restarts the enable generator. Reserved mode codes are stored and read back, but they are never made active.

Top module: `clkdiv_mode_ctrl`

## Requirements
- R1: Bits 15 to 3 of `rd_data` always read 0. Values written to those bits have no effect.
- R2: When `wr_en` is high outside reset, bits 2:0 of `wr_data` are stored in the pending field. `rd_data[2:0]` shows the pending field, with one register stage of latency.
- R3: A write never changes `active_mode`. `active_mode` changes only on an edge where `hib_exit` is high, or under the real-time-clock reset.
- R4: When `hib_exit` is high outside reset and the pending code is 000, 001, 010 or 011, that code is copied into `active_mode` on the same edge.
- R5: When `hib_exit` is high and the pending code is in the reserved range 100 to 111, `active_mode` keeps its previous value. The reserved code still reads back.
- R6: `rtc_rst` clears the pending field and `active_mode` to 000, which means divide by 2. It also clears `rd_data`.
- R7: `sys_rst` leaves the pending field and `active_mode` unchanged. While either reset is high, `wr_en` and `hib_exit` are ignored.
- R8: `bclk_en` is a one-cycle pulse every N clock cycles. N is 1 for mode 001, 2 for modes 000 and 010, and 3 for mode 011.
- R9: One edge after `active_mode` changes, the phase counter restarts with `bclk_en` low. The first pulse of the new ratio follows N edges later. `bclk_en` is low during either reset.
- R10: If `hib_exit` and `wr_en` are high on the same edge, the pending value from before the write is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rtc_rst | input | 1 | Real-time-clock reset, synchronous, active high; clears the settings |
| sys_rst | input | 1 | General reset, synchronous, active high; keeps the settings |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data (pending field, upper bits zero) |
| hib_exit | input | 1 | Single-cycle hibernate-exit strobe |
| active_mode | output | 3 | Mode code currently setting the ratio |
| bclk_en | output | 1 | Bus-clock enable pulse |

## Verification
The embedded assertions check four things on every cycle. A write lands in read-back two cycles later. `active_mode` only moves on a hibernate exit. A valid pending code is applied on that exit, and a reserved one is refused. For any ratio other than one, an enable pulse is never followed by another on the next cycle.

Some behaviour can only be shown by the bench's scenarios:
- the exact pulse spacing for each mode;
- the restart phase after a mode change;
- a write and an exit on the same edge;
- what survives each kind of reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MODE_W = 3;
  localparam int MAX_DIV = 3;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_DEFAULT = 3'b000;
  localparam mode_t MODE_DIV1    = 3'b001;
  localparam mode_t MODE_DIV2    = 3'b010;
  localparam mode_t MODE_DIV3    = 3'b011;

  // Codes with the top bit set are reserved
  function automatic logic mode_is_valid(mode_t m);
    return (m[MODE_W-1] == 1'b0);
  endfunction

  function automatic int unsigned mode_ratio(mode_t m);
    case (m)
      MODE_DIV1: return 1;
      MODE_DIV3: return 3;
      default:   return 2;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_mode_reg.sv
module clkdiv_mode_reg
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLD_W  = MODE_W
) (
  input  logic              clk,
  input  logic              rtc_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FLD_W-1:0]  pending,
  output logic [DATA_W-1:0] rd_data
);
  localparam int RSV_W = DATA_W - FLD_W;

  // Only the low field is stored; the reserved bits are not kept anywhere
  always_ff @(posedge clk) begin
    if (rtc_rst)
      pending <= '0;
    else if (wr_en && !sys_rst)
      pending <= wr_data[FLD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rtc_rst)
      rd_data <= '0;
    else
      rd_data <= {{RSV_W{1'b0}}, pending};
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rtc_rst) armed <= 1'b1;
  end

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (rtc_rst || armed !== 1'b1)
    (wr_en && !sys_rst) |-> ##2 (rd_data[FLD_W-1:0] == $past(wr_data[FLD_W-1:0], 2)));
endmodule

// File: rtl/clkdiv_active_sel.sv
module clkdiv_active_sel
  import clkdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rtc_rst,
  input  logic  sys_rst,
  input  logic  hib_exit,
  input  mode_t pending,
  output mode_t active
);
  logic take;
  assign take = hib_exit && !sys_rst && mode_is_valid(pending);

  always_ff @(posedge clk) begin
    if (rtc_rst)
      active <= MODE_DEFAULT;
    else if (take)
      active <= pending;
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rtc_rst) armed <= 1'b1;
  end

  // R3
  hold_no_exit_chk: assert property (@(posedge clk) disable iff (rtc_rst || armed !== 1'b1)
    !hib_exit |=> (active == $past(active)));

  // R4
  apply_valid_chk: assert property (@(posedge clk) disable iff (rtc_rst || armed !== 1'b1)
    (hib_exit && !sys_rst && !pending[MODE_W-1]) |=> (active == $past(pending)));

  // R5
  refuse_rsv_chk: assert property (@(posedge clk) disable iff (rtc_rst || armed !== 1'b1)
    (hib_exit && pending[MODE_W-1]) |=> (active == $past(active)));
endmodule

// File: rtl/clkdiv_en_gen.sv
module clkdiv_en_gen
  import clkdiv_pkg::*;
#(
  parameter int DIV_MAX = MAX_DIV,
  parameter int CNT_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  output logic  bclk_en
);
  mode_t            seen_mode;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] last_phase;

  assign last_phase = CNT_W'(mode_ratio(mode) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_mode <= MODE_DEFAULT;
      phase     <= '0;
      bclk_en   <= 1'b0;
    end else if (mode != seen_mode) begin
      // Restart the phase whenever the ratio source changes
      seen_mode <= mode;
      phase     <= '0;
      bclk_en   <= 1'b0;
    end else if (phase == last_phase) begin
      phase   <= '0;
      bclk_en <= 1'b1;
    end else begin
      phase   <= phase + 1'b1;
      bclk_en <= 1'b0;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R8
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
    (bclk_en && mode != MODE_DIV1 && $stable(mode)) |=> !bclk_en);
endmodule

// File: rtl/clkdiv_mode_ctrl.sv
module clkdiv_mode_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rtc_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              hib_exit,
  output logic [MODE_W-1:0] active_mode,
  output logic              bclk_en
);
  mode_t pending;
  mode_t active;

  clkdiv_mode_reg #(.DATA_W(DATA_W), .FLD_W(MODE_W)) u_reg (
    .clk     (clk),
    .rtc_rst (rtc_rst),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pending (pending),
    .rd_data (rd_data)
  );

  clkdiv_active_sel u_sel (
    .clk      (clk),
    .rtc_rst  (rtc_rst),
    .sys_rst  (sys_rst),
    .hib_exit (hib_exit),
    .pending  (pending),
    .active   (active)
  );

  clkdiv_en_gen #(.DIV_MAX(MAX_DIV)) u_gen (
    .clk     (clk),
    .rst     (rtc_rst || sys_rst),
    .mode    (active),
    .bclk_en (bclk_en)
  );

  assign active_mode = active;

  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rtc_rst)
    rd_data[DATA_W-1:MODE_W] == '0);
endmodule

// File: tb/clkdiv_mode_ctrl_tb.sv
module clkdiv_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // op codes: 0 write, 1 exit, 2 write+exit, 3 write under sys_rst, 4 exit under sys_rst
  // vector = {op[3:0], data[15:0], exp_rd[2:0], exp_active[2:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd0, 16'h0001, 3'd1, 3'd0},  // R3 write deferred
    {4'd1, 16'h0000, 3'd1, 3'd1},  // R4 applied on exit
    {4'd0, 16'hFFFB, 3'd3, 3'd1},  // R1 R2 upper bits dropped
    {4'd3, 16'h0002, 3'd3, 3'd1},  // R7 sys_rst keeps, write ignored
    {4'd1, 16'h0000, 3'd3, 3'd3},  // R4
    {4'd0, 16'h0005, 3'd5, 3'd3},  // R5 reserved stored
    {4'd1, 16'h0000, 3'd5, 3'd3},  // R5 reserved refused
    {4'd0, 16'h0001, 3'd1, 3'd3},  // R2
    {4'd2, 16'h0002, 3'd2, 3'd1},  // R10 old pending applied
    {4'd1, 16'h0000, 3'd2, 3'd2},  // R4
    {4'd0, 16'h0000, 3'd0, 3'd2},  // R2
    {4'd4, 16'h0000, 3'd0, 3'd2},  // R7 exit ignored in sys_rst
    {4'd1, 16'h0000, 3'd0, 3'd0}   // R4
  };

  logic        clk = 1'b0;
  logic        rtc_rst, sys_rst, wr_en, hib_exit;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [2:0]  active_mode;
  logic        bclk_en;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_mode_ctrl u_dut (
    .clk(clk), .rtc_rst(rtc_rst), .sys_rst(sys_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .hib_exit(hib_exit),
    .active_mode(active_mode), .bclk_en(bclk_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; hib_exit = 0; sys_rst = 0; rtc_rst = 0; wr_data = '0;
  endtask

  task automatic apply(input logic [3:0] op, input logic [15:0] d);
    @(negedge clk);
    idle();
    wr_data = d;
    case (op)
      4'd0: wr_en = 1;
      4'd1: hib_exit = 1;
      4'd2: begin wr_en = 1; hib_exit = 1; end
      4'd3: begin wr_en = 1; sys_rst = 1; end
      default: begin hib_exit = 1; sys_rst = 1; end
    endcase
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic measure(input logic [2:0] m, input int n, input string req);
    int ones = 0;
    int last = -100;
    int bad = 0;
    apply(4'd0, {13'd0, m});
    apply(4'd1, 16'h0000);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      if (bclk_en) begin
        if (i - last < n) bad++;
        ones++;
        last = i;
      end
      @(negedge clk);
    end
    chk(req, 16'(ones), 16'(12 / n));
    chk(req, 16'(bad), 16'd0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=%0d", wd, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    idle();
    rtc_rst = 1;
    repeat (3) @(negedge clk);
    rtc_rst = 0;
    // R6 reset state
    chk("R6 rd", rd_data, 16'h0000);
    chk("R6 active", {13'd0, active_mode}, 16'h0000);
    chk("R9 en in reset", {15'd0, bclk_en}, 16'h0000);

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][25:22], VEC[k][21:6]);
      chk($sformatf("R1 R2 vec%0d rd", k), rd_data, {13'd0, VEC[k][5:3]});
      chk($sformatf("R3 R4 R5 R7 vec%0d active", k), {13'd0, active_mode}, {13'd0, VEC[k][2:0]});
    end

    // R8 pulse spacing per mode
    measure(3'b001, 1, "R8 div1");
    measure(3'b000, 2, "R8 default");
    measure(3'b010, 2, "R8 div2");
    measure(3'b011, 3, "R8 div3");

    // R9 restart phase: active 1 -> 3
    apply(4'd0, 16'h0001);
    apply(4'd1, 16'h0000);
    apply(4'd0, 16'h0003);
    @(negedge clk);
    hib_exit = 1;
    @(negedge clk);
    hib_exit = 0;
    @(negedge clk);
    chk("R9 restart e2", {15'd0, bclk_en}, 16'h0000);
    @(negedge clk);
    chk("R9 restart e3", {15'd0, bclk_en}, 16'h0000);
    @(negedge clk);
    chk("R9 restart e4", {15'd0, bclk_en}, 16'h0000);
    @(negedge clk);
    chk("R9 first pulse", {15'd0, bclk_en}, 16'h0001);

    // R9 enable low under sys_rst
    sys_rst = 1;
    @(negedge clk);
    chk("R9 en in sys_rst", {15'd0, bclk_en}, 16'h0000);
    @(negedge clk);
    chk("R9 en in sys_rst 2", {15'd0, bclk_en}, 16'h0000);
    sys_rst = 0;
    chk("R7 active after sys_rst", {13'd0, active_mode}, 16'h0003);

    // R6 rtc reset clears settings that sys_rst kept
    rtc_rst = 1;
    repeat (2) @(negedge clk);
    rtc_rst = 0;
    chk("R6 rd after rtc", rd_data, 16'h0000);
    chk("R6 active after rtc", {13'd0, active_mode}, 16'h0000);
    measure(3'b000, 2, "R6 ratio 2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule